// File: doc/BRIEF.md
# Read Output Stage with Dual-Cycle Deselect

This block is the read-data output stage of a synchronous SRAM. Every clock it captures a command: idle, read, write or deselect. It takes the array's read data and drives a data bus. The bus is modelled as a value, `dq_out`, and a driver enable, `dq_oe`.

A static mode input selects the timing. In flow-through timing the array data passes straight to the bus in the cycle after the command edge. In pipelined timing the data first goes through a rising-edge output register, so it appears one cycle later. Deselect and write commands travel down the same pipeline as reads. The drivers therefore switch off at the edge where a read issued in that slot would have produced data. In pipelined mode, the bus stays on for one full cycle after the deselect is captured and turns off after the second rising edge.

An active-low output enable gates the drivers asynchronously. A sleep input parks the stage: the drivers are off, commands are dropped and the pipeline is flushed. Operation resumes when sleep falls.

Top module: `rd_out_stage`

## Requirements
- R1: After an asynchronous reset (`rst_n` low), `dq_oe` is 0 and `dq_out` is 0 until a read reaches the output.
- R2: With `mode_pipe` = 0, a read (`cmd` = 2'b01) captured at edge n sets `dq_oe` = 1 during the cycle after edge n. In that cycle `dq_out` follows `rd_data` combinationally.
- R3: With `mode_pipe` = 1, a read captured at edge n causes `rd_data` to be registered at edge n+1. That value is driven with `dq_oe` = 1 during the cycle after edge n+1.
- R4: A deselect (`cmd` = 2'b11) or idle (`cmd` = 2'b00) command has the same latency as a read. In pipelined mode, after a deselect captured at edge n, the bus keeps the state set by the previous command until edge n+1 and is off after it.
- R5: A write command (`cmd` = 2'b10) switches `dq_oe` off in exactly the cycle in which a read in the same slot would have driven data.
- R6: Back-to-back reads produce one data beat per cycle. For a four-beat burst, the first beat is sampled at the third rising edge counted from the command edge in pipelined mode and at the second in flow-through mode. The next three beats follow on consecutive edges.
- R7: `oe_n` = 1 forces `dq_oe` to 0 and `dq_out` to 0 at once, with no clock edge. Returning `oe_n` to 0 restores the pipelined state in the same cycle.
- R8: While `sleep` = 1, `dq_oe` is 0. Any command captured at an edge with `sleep` = 1 has no effect, and reads already in flight are cancelled. Reads issued after `sleep` falls behave normally.
- R9: Whenever `dq_oe` is 0, `dq_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pipe | input | 1 | 1 = pipelined output register, 0 = flow-through |
| cmd | input | 2 | Command: 00 idle, 01 read, 10 write, 11 deselect |
| rd_data | input | DATA_W | Array read data for the command captured at the previous edge |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Low-power park; drivers off, commands dropped |
| dq_out | output | DATA_W | Bus value, zero when not driven |
| dq_oe | output | 1 | Bus driver enable |

## Verification
Each of the following sequences runs in both timing modes:
- read, deselect, read;
- reads interleaved with writes;
- a four-beat burst;
- a read stream broken by output-enable pulses;
- a read stream interrupted by sleep.

Read–deselect–read separates a deselect that is pipelined from one that acts at once. It shows whether the enable turns off one edge later in pipelined mode than in flow-through mode. The burst fixes the first-beat latency and the one-beat-per-cycle rate. An enable pulse inside a cycle tells an asynchronous gate apart from a clocked one. A sleep that spans an in-flight read shows that the read is dropped and not merely delayed.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE  = 2'b00,
      CMD_READ  = 2'b01,
      CMD_WRITE = 2'b10,
      CMD_DESEL = 2'b11
   } rdo_cmd_t;
endpackage

// File: rtl/rdo_cmd_pipe.sv
module rdo_cmd_pipe
   import rdo_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sleep,
   input  rdo_cmd_t cmd_in,
   output rdo_cmd_t slot1,
   output rdo_cmd_t slot2
);
   // Two command slots; sleep flushes both so no in-flight read survives.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot1 <= CMD_IDLE;
         slot2 <= CMD_IDLE;
      end else if (sleep) begin
         slot1 <= CMD_IDLE;
         slot2 <= CMD_IDLE;
      end else begin
         slot1 <= cmd_in;
         slot2 <= slot1;
      end
   end

   // R4: the second slot always carries what the first held one edge earlier
   assert_slot_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep |=> (slot2 == $past(slot1)));
endmodule

// File: rtl/rdo_data_reg.sv
module rdo_data_reg #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] q_out
);
   if (DATA_W < 1) begin : g_bad_width
      $error("rdo_data_reg: DATA_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_out <= '0;
      else if (load) q_out <= d_in;
   end

   // R3: a load edge leaves the captured word in the register
   assert_reg_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q_out == $past(d_in)));
endmodule

// File: rtl/rdo_bus_drive.sv
module rdo_bus_drive #(
   parameter int DATA_W = 36
) (
   input  logic              mode_pipe,
   input  logic              slot1_rd,
   input  logic              slot2_rd,
   input  logic [DATA_W-1:0] flow_data,
   input  logic [DATA_W-1:0] reg_data,
   input  logic              oe_n,
   input  logic              sleep,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);
   logic              sched_on;
   logic [DATA_W-1:0] sel_data;

   always_comb begin
      sched_on = mode_pipe ? slot2_rd : slot1_rd;
      sel_data = mode_pipe ? reg_data : flow_data;
      dq_oe    = sched_on && !oe_n && !sleep;
      dq_out   = dq_oe ? sel_data : '0;
   end

   // R9: an undriven bus carries zeros
   always_comb begin
      assert_idle_zero_R9: assert (dq_oe || (dq_out == '0));
   end
endmodule

// File: rtl/rd_out_stage.sv
module rd_out_stage
   import rdo_pkg::*;
#(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_pipe,
   input  logic [1:0]        cmd,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              oe_n,
   input  logic              sleep,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);
   if (DATA_W < 1) begin : g_bad_width
      $error("rd_out_stage: DATA_W must be at least 1");
   end

   rdo_cmd_t          slot1, slot2;
   logic [DATA_W-1:0] reg_data;

   rdo_cmd_pipe u_cmd (
      .clk    (clk),
      .rst_n  (rst_n),
      .sleep  (sleep),
      .cmd_in (rdo_cmd_t'(cmd)),
      .slot1  (slot1),
      .slot2  (slot2)
   );

   rdo_data_reg #(.DATA_W(DATA_W)) u_dreg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (slot1 == CMD_READ && !sleep),
      .d_in  (rd_data),
      .q_out (reg_data)
   );

   rdo_bus_drive #(.DATA_W(DATA_W)) u_drv (
      .mode_pipe (mode_pipe),
      .slot1_rd  (slot1 == CMD_READ),
      .slot2_rd  (slot2 == CMD_READ),
      .flow_data (rd_data),
      .reg_data  (reg_data),
      .oe_n      (oe_n),
      .sleep     (sleep),
      .dq_out    (dq_out),
      .dq_oe     (dq_oe)
   );

   // R2: flow-through read drives the live array word one cycle on
   assert_flow_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_pipe && cmd == 2'b01 && !sleep) ##1 (!mode_pipe && !sleep && !oe_n)
      |-> (dq_oe && dq_out == rd_data));

   // R3: pipelined read drives two cycles on
   assert_pipe_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pipe && cmd == 2'b01 && !sleep) ##1 (mode_pipe && !sleep)
      ##1 (mode_pipe && !sleep && !oe_n) |-> dq_oe);

   // R4: a pipelined deselect turns the bus off after the second edge
   assert_desel_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pipe && cmd == 2'b11) ##1 mode_pipe ##1 mode_pipe |-> !dq_oe);

   // R5: a write slot never drives the bus, in either mode
   assert_write_off_pipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pipe && cmd == 2'b10) ##1 mode_pipe ##1 mode_pipe |-> !dq_oe);
   assert_write_off_flow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_pipe && cmd == 2'b10) ##1 !mode_pipe |-> !dq_oe);

   // R7 / R8: asynchronous gates win over the schedule
   assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n || sleep) |-> (!dq_oe && dq_out == '0));
endmodule

// File: tb/test_rd_out_stage.sv
`timescale 1ns/100ps
module test_rd_out_stage;
   localparam int DW = 36;
   localparam int NLOG = 1024;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          mode_pipe = 1;
   logic [1:0]    cmd = 2'b00;
   logic [DW-1:0] rd_data = '0;
   logic          oe_n = 0;
   logic          sleep = 0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   always #4 clk = ~clk;

   rd_out_stage #(.DATA_W(DW)) i_rd_out_stage (
      .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .cmd(cmd),
      .rd_data(rd_data), .oe_n(oe_n), .sleep(sleep),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 2;
   bit done = 0;
   logic [1:0]    cmd_log [NLOG];
   bit            slp_log [NLOG];
   logic [DW-1:0] rd_log  [NLOG];

   task automatic compare(input string tag, input logic exp_oe, input logic [DW-1:0] exp_d);
      n_cmp++;
      if (dq_oe !== exp_oe || dq_out !== exp_d) begin
         n_bad++;
         $display("FAIL %s cycle %0d: oe=%b out=%h expected oe=%b out=%h",
                  tag, cyc, dq_oe, dq_out, exp_oe, exp_d);
      end
   endtask

   function automatic bit rd_at(int k);
      return cmd_log[k] == 2'b01 && !slp_log[k];
   endfunction

   // behavioural expectation for the current cycle
   task automatic expect_now(output logic e_oe, output logic [DW-1:0] e_d);
      if (mode_pipe) begin
         e_oe = rd_at(cyc - 2) && !slp_log[cyc - 1];
         e_d  = rd_log[cyc - 1];
      end else begin
         e_oe = rd_at(cyc - 1);
         e_d  = rd_log[cyc];
      end
      e_oe = e_oe && !oe_n && !sleep;
      if (!e_oe) e_d = '0;
   endtask

   task automatic step(input logic [1:0] c, input logic o, input logic s,
                       input bit pulse, input string tag);
      logic          e_oe;
      logic [DW-1:0] e_d;
      @(posedge clk);
      cyc++;
      #1;
      cmd = c; oe_n = o; sleep = s;
      rd_data = DW'(cyc) * 36'h9E37 ^ 36'hA_5A5A_5A5A;
      cmd_log[cyc] = c; slp_log[cyc] = s; rd_log[cyc] = rd_data;
      #5;
      expect_now(e_oe, e_d);
      compare(tag, e_oe, e_d);
      if (pulse) begin
         oe_n = 1;
         #0.5;
         compare("R7", 1'b0, '0);
         oe_n = o;
         #0.5;
         compare("R7", e_oe, e_d);
      end
   endtask

   task automatic run_mode(input logic m);
      int first;
      int on_cnt;
      int c0;
      string main_tag;
      main_tag = m ? "R3" : "R2";
      mode_pipe = m;
      repeat (3) step(2'b00, 0, 0, 0, "R9");
      // read - deselect - read
      step(2'b01, 0, 0, 0, main_tag);
      step(2'b11, 0, 0, 0, "R4");
      step(2'b01, 0, 0, 0, "R4");
      step(2'b11, 0, 0, 0, "R4");
      step(2'b11, 0, 0, 0, "R4");
      step(2'b01, 0, 0, 0, main_tag);
      repeat (3) step(2'b00, 0, 0, 0, "R9");
      // reads interleaved with writes
      for (int i = 0; i < 6; i++) step(i[0] ? 2'b10 : 2'b01, 0, 0, 0, "R5");
      repeat (3) step(2'b00, 0, 0, 0, "R5");
      // four-beat burst
      c0 = cyc + 1; first = 0; on_cnt = 0;
      for (int i = 0; i < 8; i++) begin
         step(i < 4 ? 2'b01 : 2'b00, 0, 0, 0, "R6");
         if (dq_oe) begin
            on_cnt++;
            if (first == 0) first = cyc;
         end
      end
      n_cmp++;
      if (first - c0 != (m ? 2 : 1) || on_cnt != 4) begin
         n_bad++;
         $display("FAIL R6 mode %b: first beat offset %0d beats %0d expected offset %0d beats 4",
                  m, first - c0, on_cnt, m ? 2 : 1);
      end
      // output-enable gating, clocked and mid-cycle
      for (int i = 0; i < 7; i++) step(2'b01, (i == 3 || i == 4), 0, (i == 5), "R7");
      repeat (3) step(2'b00, 0, 0, 0, "R7");
      // sleep across an in-flight read, then resume
      step(2'b01, 0, 0, 0, "R8");
      step(2'b01, 0, 1, 0, "R8");
      step(2'b01, 0, 1, 0, "R8");
      step(2'b00, 0, 0, 0, "R8");
      step(2'b00, 0, 0, 0, "R8");
      step(2'b01, 0, 0, 0, "R8");
      step(2'b01, 0, 0, 0, "R8");
      repeat (3) step(2'b00, 0, 0, 0, "R8");
   endtask

   initial begin
      for (int i = 0; i < NLOG; i++) begin
         cmd_log[i] = 2'b00; slp_log[i] = 0; rd_log[i] = '0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #5 compare("R1", 1'b0, '0);
      run_mode(1'b0);
      run_mode(1'b1);
      run_mode(1'b0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule